// File: doc/BRIEF.md
# Bridge Command Function Dispatcher

This block sits behind an I2C slave front end that has already decoded bits into bytes and flagged start, stop and address-match events. In each write transaction it reads the first byte after the address as a function code and carries it out. Three codes are recognised. One returns the active-low interrupt line high. One puts the bridge into a low-power idle state. One loads a general-purpose output latch from the byte that follows it.

The interrupt line goes low on every completion pulse from the SPI transfer engine. It stays low until a host clears it, so a host that polls can ignore it. The slave-select pins are shared between two uses. A per-pin port-enable mask picks, for each pin, either the SPI engine's active-low chip select or the matching bit of the output latch. A parameter sets the number of select pins, either four or three.

Top module: `bridge_fn_dispatch`

## Requirements
- R1: After reset `irq_n` is 1, `idle` is 0 and every output latch bit is 0, so a pin in output mode drives 0.
- R2: A pulse on `spi_done` makes `irq_n` 0 at the next clock edge. It stays 0 for as long as no clear command is carried out.
- R3: When the first byte after an address match is F1h, `irq_n` returns to 1 at the next edge. If `spi_done` is high in that same cycle, `irq_n` goes to 0 instead.
- R4: When the first byte after an address match is F2h, `idle` becomes 1 at the next edge. While `idle` is 1, received bytes have no effect on `irq_n` or on the latch.
- R5: A pulse on `i2c_addr_match` clears `idle` at the next edge. A byte presented in the cycle after the pulse is taken as the function code. A byte presented in the same cycle as the pulse is ignored.
- R6: When the first byte is F4h, the next byte loads the latch. Bit k of that byte sets latch bit k. Bits 7 to 4 are ignored. Any later bytes in the same transaction are ignored.
- R7: An F4h code followed by a stop, with no data byte before the stop, leaves the latch unchanged.
- R8: A first byte that is none of F1h, F2h or F4h has no effect. Only the first byte after the address is read as a code, so F1h in second position leaves `irq_n` unchanged.
- R9: Each `ss_n[k]` equals latch bit k when `port_gpio_en[k]` is 1, and `spi_cs_n[k]` when it is 0. The selection is combinational.
- R10: With `NUM_SS` = 3 only three select pins exist. Bit 3 of the data byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i2c_start | input | 1 | Start or repeated-start pulse |
| i2c_stop | input | 1 | Stop pulse |
| i2c_addr_match | input | 1 | Own address matched in a write, one-cycle pulse |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| spi_done | input | 1 | SPI transfer completion pulse |
| spi_cs_n | input | NUM_SS | Active-low chip selects from the SPI engine |
| port_gpio_en | input | NUM_SS | 1 = pin is a general-purpose output |
| irq_n | output | 1 | Active-low interrupt |
| idle | output | 1 | Low-power idle flag |
| ss_n | output | NUM_SS | Slave-select / output pins |

## Verification
The directed cases cover each function code on its own. They also cover a clear that lands in the same cycle as a completion, a data byte with the upper nibble set (to show it is masked), extra trailing bytes, a stop before the data byte, a code in second position, and a byte that arrives in the same cycle as the address match. The random phase mixes valid, unknown and repeated codes with random completion pulses, enable masks and chip selects. A cycle-by-cycle model built from the requirements is compared against the design, which shows whether every byte position and event ordering is decoded correctly. A second instance with three selects separates masking of bit 3 from the four-pin case.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  localparam logic [7:0] FID_CLR_IRQ = 8'hF1;
  localparam logic [7:0] FID_IDLE    = 8'hF2;
  localparam logic [7:0] FID_GPIO_WR = 8'hF4;

  typedef enum logic [1:0] {
    PH_WAIT_ADDR = 2'd0,
    PH_FUNC_ID   = 2'd1,
    PH_GPIO_DATA = 2'd2,
    PH_SKIP      = 2'd3
  } phase_e;
endpackage

// File: rtl/bfd_rst_sync.sv
module bfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bfd_cmd_parser.sv
module bfd_cmd_parser
  import bfd_pkg::*;
#(
  parameter int NUM_SS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_match_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              idle_o,
  output logic              clr_irq_o,
  output logic              gpio_wr_o,
  output logic [NUM_SS-1:0] gpio_bits_o
);
  phase_e phase_q, phase_d;
  logic   idle_q, idle_d;
  logic   accept;

  assign accept = byte_valid_i && !idle_q && !addr_match_i && !start_i && !stop_i;

  always_comb begin
    phase_d   = phase_q;
    idle_d    = idle_q;
    clr_irq_o = 1'b0;
    gpio_wr_o = 1'b0;
    if (addr_match_i) begin
      phase_d = PH_FUNC_ID;
      idle_d  = 1'b0;
    end else if (start_i || stop_i) begin
      phase_d = PH_WAIT_ADDR;
    end else if (accept) begin
      unique case (phase_q)
        PH_FUNC_ID: begin
          phase_d = PH_SKIP;
          if (byte_i == FID_CLR_IRQ) begin
            clr_irq_o = 1'b1;
          end else if (byte_i == FID_IDLE) begin
            idle_d = 1'b1;
          end else if (byte_i == FID_GPIO_WR) begin
            phase_d = PH_GPIO_DATA;
          end
        end
        PH_GPIO_DATA: begin
          gpio_wr_o = 1'b1;
          phase_d   = PH_SKIP;
        end
        default: begin
          phase_d = phase_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT_ADDR;
      idle_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idle_q  <= idle_d;
    end
  end

  assign idle_o      = idle_q;
  assign gpio_bits_o = byte_i[NUM_SS-1:0];

  AST_IDLE_ONLY_BY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(byte_valid_i && byte_i == FID_IDLE)); // R4
  AST_MATCH_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && addr_match_i) |=> !idle_q); // R5
endmodule

// File: rtl/bfd_irq_ctrl.sv
module bfd_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_done_i,
  input  logic clr_i,
  output logic irq_n_o
);
  logic irq_n_q, irq_n_d, irq_en;

  assign irq_en = spi_done_i || clr_i;

  always_comb begin
    irq_n_d = irq_n_q;
    if (spi_done_i) begin
      irq_n_d = 1'b0;
    end else if (clr_i) begin
      irq_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else if (irq_en) begin
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n_o = irq_n_q;

  AST_DONE_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_done_i |=> !irq_n_o); // R2
  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !clr_i) |=> !irq_n_o); // R2
  AST_CLEAR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !spi_done_i) |=> irq_n_o); // R3
endmodule

// File: rtl/bfd_gpio_port.sv
module bfd_gpio_port #(
  parameter int NUM_SS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [NUM_SS-1:0] wr_bits_i,
  input  logic [NUM_SS-1:0] gpio_en_i,
  input  logic [NUM_SS-1:0] cs_n_i,
  output logic [NUM_SS-1:0] latch_o,
  output logic [NUM_SS-1:0] pin_o
);
  logic [NUM_SS-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (wr_i) begin
      latch_q <= wr_bits_i;
    end
  end

  for (genvar k = 0; k < NUM_SS; k++) begin : g_pin
    assign pin_o[k] = gpio_en_i[k] ? latch_q[k] : cs_n_i[k];
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/bridge_fn_dispatch.sv
module bridge_fn_dispatch #(
  parameter int NUM_SS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i2c_start,
  input  logic              i2c_stop,
  input  logic              i2c_addr_match,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              spi_done,
  input  logic [NUM_SS-1:0] spi_cs_n,
  input  logic [NUM_SS-1:0] port_gpio_en,
  output logic              irq_n,
  output logic              idle,
  output logic [NUM_SS-1:0] ss_n
);
  localparam int SS_MAX = 4;

  logic              rst_n_int;
  logic              clr_irq;
  logic              gpio_wr;
  logic [NUM_SS-1:0] gpio_bits;
  logic [NUM_SS-1:0] latch_bits;

  initial begin
    if (NUM_SS < 1 || NUM_SS > SS_MAX) $error("NUM_SS out of range");
  end

  bfd_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  bfd_cmd_parser #(.NUM_SS(NUM_SS)) u_parser (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (i2c_start),
    .stop_i       (i2c_stop),
    .addr_match_i (i2c_addr_match),
    .byte_valid_i (rx_valid),
    .byte_i       (rx_byte),
    .idle_o       (idle),
    .clr_irq_o    (clr_irq),
    .gpio_wr_o    (gpio_wr),
    .gpio_bits_o  (gpio_bits)
  );

  bfd_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .spi_done_i (spi_done),
    .clr_i      (clr_irq),
    .irq_n_o    (irq_n)
  );

  bfd_gpio_port #(.NUM_SS(NUM_SS)) u_port (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_i      (gpio_wr),
    .wr_bits_i (gpio_bits),
    .gpio_en_i (port_gpio_en),
    .cs_n_i    (spi_cs_n),
    .latch_o   (latch_bits),
    .pin_o     (ss_n)
  );

  AST_IDLE_FREEZES_LATCH: assert property (@(posedge clk) disable iff (!rst_n_int)
    (idle && !i2c_addr_match) |=> $stable(latch_bits)); // R4
  AST_IDLE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (idle && !i2c_addr_match && !spi_done) |=> $stable(irq_n)); // R4
endmodule

// File: tb/bridge_fn_dispatch_tb.sv
module bridge_fn_dispatch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       i2c_start = 1'b0, i2c_stop = 1'b0, i2c_addr_match = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       spi_done = 1'b0;
  logic [3:0] spi_cs_n = 4'hF, port_gpio_en = 4'hF;
  logic       irq_n, idle, irq_n3, idle3;
  logic [3:0] ss_n;
  logic [2:0] ss_n3;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0, done_flag = 1'b0;

  always #10 clk = ~clk;

  bridge_fn_dispatch #(.NUM_SS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
    .i2c_addr_match(i2c_addr_match), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .spi_done(spi_done), .spi_cs_n(spi_cs_n), .port_gpio_en(port_gpio_en),
    .irq_n(irq_n), .idle(idle), .ss_n(ss_n));

  bridge_fn_dispatch #(.NUM_SS(3)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
    .i2c_addr_match(i2c_addr_match), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .spi_done(spi_done), .spi_cs_n(spi_cs_n[2:0]), .port_gpio_en(port_gpio_en[2:0]),
    .irq_n(irq_n3), .idle(idle3), .ss_n(ss_n3));

  // Reference model built from the requirements
  logic [1:0] m_ph;
  logic       m_idle, m_irq, m_acc, m_clr;
  logic [3:0] m_lat;
  logic [2:0] m_lat3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 2'd0; m_idle = 1'b0; m_irq = 1'b1; m_lat = 4'h0; m_lat3 = 3'h0;
    end else begin
      m_acc = rx_valid && !m_idle && !i2c_addr_match && !i2c_start && !i2c_stop;
      m_clr = m_acc && (m_ph == 2'd1) && (rx_byte == 8'hF1);
      if (i2c_addr_match) begin
        m_ph = 2'd1; m_idle = 1'b0;
      end else if (i2c_start || i2c_stop) begin
        m_ph = 2'd0;
      end else if (m_acc) begin
        if (m_ph == 2'd1) begin
          m_ph = (rx_byte == 8'hF4) ? 2'd2 : 2'd3;
          if (rx_byte == 8'hF2) m_idle = 1'b1;
        end else if (m_ph == 2'd2) begin
          m_lat = rx_byte[3:0]; m_lat3 = rx_byte[2:0]; m_ph = 2'd3;
        end
      end
      if (spi_done) m_irq = 1'b0;
      else if (m_clr) m_irq = 1'b1;
    end
  end

  function automatic logic [3:0] exp_pins(input logic [3:0] lat, input logic [3:0] en,
                                          input logic [3:0] cs);
    exp_pins = (en & lat) | (~en & cs);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check("R2/R3 irq_n model", {31'd0, irq_n}, {31'd0, m_irq});
      check("R4/R5 idle model", {31'd0, idle}, {31'd0, m_idle});
      check("R9 ss_n model", {28'd0, ss_n}, {28'd0, exp_pins(m_lat, port_gpio_en, spi_cs_n)});
      check("R10 ss_n3 model", {29'd0, ss_n3},
            {29'd0, exp_pins({1'b0, m_lat3}, port_gpio_en, spi_cs_n) & 4'h7});
    end
  end

  task automatic put(input logic m, input logic st, input logic sp, input logic bv,
                     input logic [7:0] b, input logic d);
    @(posedge clk); #1;
    i2c_addr_match = m; i2c_start = st; i2c_stop = sp; rx_valid = bv; rx_byte = b; spi_done = d;
  endtask

  task automatic quiet(); put(0, 0, 0, 0, 8'h00, 0); endtask

  task automatic begin_txn(); put(0, 1, 0, 0, 8'h00, 0); put(1, 0, 0, 0, 8'h00, 0); endtask
  task automatic send(input logic [7:0] b); put(0, 0, 0, 1, b, 0); endtask
  task automatic end_txn(); put(0, 0, 1, 0, 8'h00, 0); quiet(); @(negedge clk); endtask
  task automatic pulse_done(); put(0, 0, 0, 0, 8'h00, 1); quiet(); @(negedge clk); endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {31'd0, irq_n}, 32'd1);
    check("R1 idle", {31'd0, idle}, 32'd0);
    check("R1 ss_n latch zero", {28'd0, ss_n}, 32'd0);
    chk_en = 1'b1;

    // R2 completion lowers interrupt and it stays low
    pulse_done();
    check("R2 irq_n low", {31'd0, irq_n}, 32'd0);
    repeat (5) @(negedge clk);
    check("R2 irq_n held", {31'd0, irq_n}, 32'd0);

    // R3 clear
    begin_txn(); send(8'hF1); end_txn();
    check("R3 irq_n cleared", {31'd0, irq_n}, 32'd1);
    // R3 collision: completion wins
    begin_txn(); put(0, 0, 0, 1, 8'hF1, 1); end_txn();
    check("R3 collision irq_n", {31'd0, irq_n}, 32'd0);

    // R8 unknown code then F1 in second place
    begin_txn(); send(8'h55); send(8'hF1); end_txn();
    check("R8 second-position F1 ignored", {31'd0, irq_n}, 32'd0);

    // R6 gpio write with upper nibble set, plus a trailing byte
    port_gpio_en = 4'hF;
    begin_txn(); send(8'hF4); send(8'hAD); send(8'h02); end_txn();
    check("R6 latch from data", {28'd0, ss_n}, 32'hD);
    check("R10 three-select bit3 ignored", {29'd0, ss_n3}, 32'h5);

    // R7 F4 then stop
    begin_txn(); send(8'hF4); end_txn();
    check("R7 latch unchanged", {28'd0, ss_n}, 32'hD);

    // R4 idle, bytes ignored
    begin_txn(); send(8'hF2); end_txn();
    check("R4 idle set", {31'd0, idle}, 32'd1);
    send(8'hF1); send(8'hF4); send(8'h00); end_txn();
    check("R4 irq unchanged in idle", {31'd0, irq_n}, 32'd0);
    check("R4 latch unchanged in idle", {28'd0, ss_n}, 32'hD);

    // R5 match exits idle, following byte taken as a code
    put(1, 0, 0, 0, 8'h00, 0); quiet(); @(negedge clk);
    check("R5 idle cleared", {31'd0, idle}, 32'd0);
    put(1, 0, 0, 0, 8'h00, 0); send(8'hF4); send(8'h03); end_txn();
    check("R5 byte after match decoded", {28'd0, ss_n}, 32'h3);
    // R5 byte in same cycle as match ignored
    put(1, 0, 0, 1, 8'hF1, 0); end_txn();
    check("R5 same-cycle byte ignored", {31'd0, irq_n}, 32'd0);

    // R9 mux
    port_gpio_en = 4'h0; spi_cs_n = 4'hA; #1;
    check("R9 all chip-select", {28'd0, ss_n}, 32'hA);
    port_gpio_en = 4'h6; spi_cs_n = 4'h9; #1;
    check("R9 mixed", {28'd0, ss_n}, {28'd0, exp_pins(4'h3, 4'h6, 4'h9)});

    // Random phase
    for (int t = 0; t < 400; t++) begin
      int nb;
      port_gpio_en = 4'($urandom);
      spi_cs_n = 4'($urandom);
      begin_txn();
      nb = int'($urandom % 4);
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b;
        case ($urandom % 5)
          0: b = 8'hF1;
          1: b = 8'hF2;
          2: b = 8'hF4;
          default: b = 8'($urandom);
        endcase
        put(0, 0, 0, 1, b, ($urandom % 8) == 0);
        if ($urandom % 3 == 0) put(0, 0, 0, 0, 8'h00, ($urandom % 6) == 0);
      end
      put(0, 0, 1, 0, 8'h00, ($urandom % 8) == 0);
      quiet();
    end
    @(negedge clk);
    chk_en = 1'b0;
    finish_run();
  end
endmodule